// File: doc/BRIEF.md
# Converter Command Register Sequencer

This block is the command register of an analog-to-digital converter, together with the small state machine that decides which commands software may issue. Software writes one word that carries several command bits: power-up, power-down, regular conversion start, injected conversion start, stop, calibration, and a voltage-regulator enable. Each command bit can only be set by writing 1, and only when the register is in a legal state for that command. The converter core ends each command with a status event, and that event clears the bit in hardware.

Every accepted command sends a one-cycle pulse to the core. Regular conversions are launched in one of two ways. With software triggering, the launch happens as soon as the start is accepted. With a hardware trigger, an accepted start only arms the block, and each rising trigger edge launches a conversion. Writes that break a legality rule leave the affected bit unchanged and set a sticky error flag. The readback word also carries a ready flag that the core raises after power-up.

Top module: `adc_cmd_ctrl`

## Requirements
- R1: A write with bit 0 (enable) set is accepted only if, before the write, command bits 0 to 5 are all 0 and the regulator bit 6 reads 1. A refused enable leaves bit 0 at 0.
- R2: After enable is accepted, ready (readback bit 8) reads 0 until a `core_ready` event arrives while enable=1 and disable=0. Ready then reads 1 from the next cycle.
- R3: A write with bit 1 (disable) set is accepted only when enable=1, disable=0, regular start (bit 2)=0 and injected start (bit 3)=0.
- R4: Disable reads 1 until a `core_off` event arrives. On that event, hardware clears disable, enable and ready in the same cycle.
- R5: A write with bit 2 (regular start) set is accepted only when enable=1, disable=0 and regular start=0.
- R6: When `cfg_trig_sel`=0 (software trigger), `go_reg_conv` pulses in the cycle after regular start is accepted. When `cfg_continuous`=0, a `core_seq_end` event clears regular start. When `cfg_continuous`=1, `core_seq_end` leaves regular start set.
- R7: When `cfg_trig_sel` is nonzero (hardware trigger), accepting regular start only arms the block. `go_reg_conv` pulses one cycle after each sampled rising edge of `hw_trig` while regular start already reads 1. `core_seq_end` does not clear regular start in this mode.
- R8: A write with bit 4 (stop) set is accepted only when regular start=1 and stop=0. A `core_stop_done` event clears stop and regular start in the same cycle.
- R9: When `cfg_auto_inj`=1, every regular launch pulses `go_inj_conv` together with `go_reg_conv`, and writes with bit 3 set are refused. When `cfg_auto_inj`=0, bit 3 is accepted when enable=1, disable=0 and injected start=0. A `core_inj_end` event clears it.
- R10: A write with bit 5 (calibrate) set is accepted under the same condition as enable. If bits 0 and 5 are set in the same write, calibrate is accepted and enable is refused. A `core_cal_done` event clears bit 5.
- R11: A write whose 1 bits include a command that is refused leaves that bit unchanged and sets the sticky error flag (readback bit 9). Only reset clears the error flag.
- R12: Writing 0 to a command bit has no effect. Bit 6 (regulator) takes the written value on every write. `bus_rdata` reads all zero while `bus_rd`=0.
- R13: Reset clears every bit and pulse. The enable, disable, stop, calibrate and injected start commands (injected start only when `cfg_auto_inj`=0) each give exactly one single-cycle pulse, in the cycle after the accepting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 7 | Write data: command bits 5:0, regulator bit 6 |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Readback word |
| cfg_trig_sel | input | TRIG_W | Trigger source: 0 selects software trigger |
| cfg_continuous | input | 1 | Continuous conversion mode |
| cfg_auto_inj | input | 1 | Auto-injection mode |
| hw_trig | input | 1 | Hardware trigger line |
| core_ready | input | 1 | Core reports ready after power-up |
| core_off | input | 1 | Core reports power-down complete |
| core_seq_end | input | 1 | End of regular sequence |
| core_stop_done | input | 1 | Stop command complete |
| core_inj_end | input | 1 | End of injected sequence |
| core_cal_done | input | 1 | Calibration complete |
| go_enable | output | 1 | Power-up command pulse |
| go_disable | output | 1 | Power-down command pulse |
| go_reg_conv | output | 1 | Regular conversion launch pulse |
| go_inj_conv | output | 1 | Injected conversion launch pulse |
| go_stop | output | 1 | Stop command pulse |
| go_calib | output | 1 | Calibration command pulse |

## Verification
The bench builds the block with DW=16 and TRIG_W=2. The narrow readback word keeps the unused upper bits visible in every comparison. The two-bit trigger field means that random configuration changes select software triggering about a quarter of the time. This lets the random phase reach both launch paths, and switches between them while regular start is armed. Random writes set the regulator bit most of the time, so the enable and calibrate legality paths are reached often, alongside the refusals.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam int NCMD     = 6;
  localparam int B_EN     = 0;
  localparam int B_DIS    = 1;
  localparam int B_RS     = 2;
  localparam int B_JS     = 3;
  localparam int B_STP    = 4;
  localparam int B_CAL    = 5;
  localparam int POS_VREG = 6;
  localparam int POS_RDY  = 8;
  localparam int POS_ERR  = 9;
  localparam int WR_W     = POS_VREG + 1;
  localparam int RD_MIN   = POS_ERR + 1;
endpackage

// File: rtl/adc_cmd_legal.sv
module adc_cmd_legal import adc_cmd_pkg::*; (
  input  logic            wr_en,
  input  logic [NCMD-1:0] wr_set,
  input  logic [NCMD-1:0] cmd,
  input  logic            vreg,
  input  logic            auto_inj,
  output logic [NCMD-1:0] accept,
  output logic            reject
);
  logic            idle;
  logic            active;
  logic [NCMD-1:0] legal;

  always_comb begin
    idle   = (cmd == '0);
    active = cmd[B_EN] & ~cmd[B_DIS];
    legal          = '0;
    legal[B_EN]    = idle & vreg & ~wr_set[B_CAL];
    legal[B_DIS]   = active & ~cmd[B_RS] & ~cmd[B_JS];
    legal[B_RS]    = active & ~cmd[B_RS];
    legal[B_JS]    = active & ~cmd[B_JS] & ~auto_inj;
    legal[B_STP]   = cmd[B_RS] & ~cmd[B_STP];
    legal[B_CAL]   = idle & vreg;
    accept = {NCMD{wr_en}} & wr_set & legal;
    reject = wr_en & (|(wr_set & ~legal));
  end
endmodule

// File: rtl/adc_cmd_bits.sv
module adc_cmd_bits import adc_cmd_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMD-1:0] accept,
  input  logic [NCMD-1:0] clear,
  output logic [NCMD-1:0] cmd
);
  logic [NCMD-1:0] cmd_q;
  logic [NCMD-1:0] cmd_d;
  logic [NCMD-1:0] upd;

  for (genvar i = 0; i < NCMD; i++) begin : g_bit
    always_comb begin
      upd[i]   = accept[i] | clear[i];
      cmd_d[i] = (cmd_q[i] & ~clear[i]) | accept[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmd_q[i] <= 1'b0;
      else if (upd[i]) cmd_q[i] <= cmd_d[i];
    end
  end

  assign cmd = cmd_q;

  // R11
  no_set_clr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(accept & clear)));
endmodule

// File: rtl/adc_cmd_launch.sv
module adc_cmd_launch import adc_cmd_pkg::*; #(
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCMD-1:0]   accept,
  input  logic [NCMD-1:0]   cmd,
  input  logic [TRIG_W-1:0] trig_sel,
  input  logic              auto_inj,
  input  logic              hw_trig,
  output logic [NCMD-1:0]   go
);
  logic            trig_q;
  logic            rise;
  logic            sw_mode;
  logic            launch;
  logic [NCMD-1:0] go_d;
  logic [NCMD-1:0] go_q;

  always_comb begin
    rise     = hw_trig & ~trig_q;
    sw_mode  = (trig_sel == '0);
    launch   = sw_mode ? accept[B_RS] : (cmd[B_RS] & rise);
    go_d        = accept;
    go_d[B_RS]  = launch;
    go_d[B_JS]  = accept[B_JS] | (launch & auto_inj);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      go_q   <= '0;
    end else begin
      trig_q <= hw_trig;
      go_q   <= go_d;
    end
  end

  assign go = go_q;

  // R7
  hw_launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q[B_RS] && $past(trig_sel != '0)) |-> $past(hw_trig && !trig_q));

  // R9
  auto_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q[B_RS] && $past(auto_inj)) |-> go_q[B_JS]);
endmodule

// File: rtl/adc_cmd_status.sv
module adc_cmd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_evt,
  input  logic off_done,
  input  logic en,
  input  logic dis,
  input  logic reject,
  output logic ready,
  output logic err
);
  logic rdy_q, rdy_d, rdy_upd;
  logic err_q, err_d;

  always_comb begin
    rdy_upd = off_done | (rdy_evt & en & ~dis);
    rdy_d   = ~off_done;
    err_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdy_q <= 1'b0;
    else if (rdy_upd) rdy_q <= rdy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (reject) err_q <= err_d;
  end

  assign ready = rdy_q;
  assign err   = err_q;

  // R2
  rdy_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> en);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_q));
endmodule

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl import adc_cmd_pkg::*; #(
  parameter int DW     = 32,
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [WR_W-1:0]   bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic [TRIG_W-1:0] cfg_trig_sel,
  input  logic              cfg_continuous,
  input  logic              cfg_auto_inj,
  input  logic              hw_trig,
  input  logic              core_ready,
  input  logic              core_off,
  input  logic              core_seq_end,
  input  logic              core_stop_done,
  input  logic              core_inj_end,
  input  logic              core_cal_done,
  output logic              go_enable,
  output logic              go_disable,
  output logic              go_reg_conv,
  output logic              go_inj_conv,
  output logic              go_stop,
  output logic              go_calib
);
  logic            sync_q, srst_n;
  logic [NCMD-1:0] cmd, accept, clear, go;
  logic            reject, vreg_q, vreg_d, ready, err, sw_mode;
  logic [DW-1:0]   rd_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      sync_q <= 1'b1;
      srst_n <= sync_q;
    end
  end

  adc_cmd_legal u_legal (
    .wr_en    (bus_wr),
    .wr_set   (bus_wdata[NCMD-1:0]),
    .cmd      (cmd),
    .vreg     (vreg_q),
    .auto_inj (cfg_auto_inj),
    .accept   (accept),
    .reject   (reject)
  );

  always_comb begin
    sw_mode       = (cfg_trig_sel == '0);
    clear         = '0;
    clear[B_EN]   = core_off & cmd[B_DIS];
    clear[B_DIS]  = core_off & cmd[B_DIS];
    clear[B_RS]   = cmd[B_RS] & ((core_seq_end & sw_mode & ~cfg_continuous) |
                                 (core_stop_done & cmd[B_STP]));
    clear[B_JS]   = core_inj_end & cmd[B_JS];
    clear[B_STP]  = core_stop_done & cmd[B_STP];
    clear[B_CAL]  = core_cal_done & cmd[B_CAL];
  end

  adc_cmd_bits u_bits (
    .clk    (clk),
    .rst_n  (srst_n),
    .accept (accept),
    .clear  (clear),
    .cmd    (cmd)
  );

  adc_cmd_launch #(.TRIG_W(TRIG_W)) u_launch (
    .clk      (clk),
    .rst_n    (srst_n),
    .accept   (accept),
    .cmd      (cmd),
    .trig_sel (cfg_trig_sel),
    .auto_inj (cfg_auto_inj),
    .hw_trig  (hw_trig),
    .go       (go)
  );

  adc_cmd_status u_status (
    .clk      (clk),
    .rst_n    (srst_n),
    .rdy_evt  (core_ready),
    .off_done (clear[B_EN]),
    .en       (cmd[B_EN]),
    .dis      (cmd[B_DIS]),
    .reject   (reject),
    .ready    (ready),
    .err      (err)
  );

  always_comb vreg_d = bus_wr ? bus_wdata[POS_VREG] : vreg_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     vreg_q <= 1'b0;
    else if (bus_wr) vreg_q <= vreg_d;
  end

  always_comb begin
    rd_word                = '0;
    rd_word[NCMD-1:0]      = cmd;
    rd_word[POS_VREG]      = vreg_q;
    rd_word[POS_RDY]       = ready;
    rd_word[POS_ERR]       = err;
  end

  assign bus_rdata   = bus_rd ? rd_word : '0;
  assign go_enable   = go[B_EN];
  assign go_disable  = go[B_DIS];
  assign go_reg_conv = go[B_RS];
  assign go_inj_conv = go[B_JS];
  assign go_stop     = go[B_STP];
  assign go_calib    = go[B_CAL];

  // R1
  en_rise_legal_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(cmd[B_EN]) |-> $past(cmd == '0 && vreg_q));

  // R3
  dis_rise_legal_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(cmd[B_DIS]) |-> $past(cmd[B_EN] && !cmd[B_RS] && !cmd[B_JS]));

  // R4
  dis_en_fall_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(cmd[B_DIS]) |-> $fell(cmd[B_EN]));

  // R8
  stop_fall_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(cmd[B_STP]) |-> !cmd[B_RS]);

  // R9
  inj_auto_block_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(cmd[B_JS]) |-> !$past(cfg_auto_inj));
endmodule

// File: tb/test_adc_cmd_ctrl.sv
`timescale 1ns/1ps
module test_adc_cmd_ctrl;
  localparam int DW = 16;
  localparam int TW = 2;
  localparam logic [6:0] W_EN = 7'h01, W_DIS = 7'h02, W_RS = 7'h04, W_JS = 7'h08;
  localparam logic [6:0] W_STP = 7'h10, W_CAL = 7'h20, W_VR = 7'h40;
  localparam logic [5:0] E_RDY = 6'h01, E_OFF = 6'h02, E_EOS = 6'h04;
  localparam logic [5:0] E_STP = 6'h08, E_INJ = 6'h10, E_CAL = 6'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b1;
  logic [6:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [TW-1:0] cfg_trig_sel = '0;
  logic cfg_continuous = 1'b0, cfg_auto_inj = 1'b0, hw_trig = 1'b0;
  logic core_ready = 1'b0, core_off = 1'b0, core_seq_end = 1'b0;
  logic core_stop_done = 1'b0, core_inj_end = 1'b0, core_cal_done = 1'b0;
  logic go_enable, go_disable, go_reg_conv, go_inj_conv, go_stop, go_calib;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] m_cmd = '0;
  logic m_vreg = 1'b0, m_rdy = 1'b0, m_err = 1'b0, m_trq = 1'b0;
  logic [DW-1:0] exp_word;
  logic [5:0] exp_go;

  always #2 clk = ~clk;

  adc_cmd_ctrl #(.DW(DW), .TRIG_W(TW)) i_adc_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cfg_trig_sel(cfg_trig_sel),
    .cfg_continuous(cfg_continuous), .cfg_auto_inj(cfg_auto_inj),
    .hw_trig(hw_trig), .core_ready(core_ready), .core_off(core_off),
    .core_seq_end(core_seq_end), .core_stop_done(core_stop_done),
    .core_inj_end(core_inj_end), .core_cal_done(core_cal_done),
    .go_enable(go_enable), .go_disable(go_disable), .go_reg_conv(go_reg_conv),
    .go_inj_conv(go_inj_conv), .go_stop(go_stop), .go_calib(go_calib)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected behaviour taken from the requirements
  task automatic model_step(input logic w, input logic [6:0] d, input logic [5:0] ev,
                            input logic trig);
    logic [5:0] c, lg, acc, clr, go;
    logic idle, act, sw, launch, rej;
    c    = m_cmd;
    idle = (c == '0);
    act  = c[0] & ~c[1];
    sw   = (cfg_trig_sel == '0);
    lg[0] = idle & m_vreg & ~d[5];            // R1, R10
    lg[1] = act & ~c[2] & ~c[3];              // R3
    lg[2] = act & ~c[2];                      // R5
    lg[3] = act & ~c[3] & ~cfg_auto_inj;      // R9
    lg[4] = c[2] & ~c[4];                     // R8
    lg[5] = idle & m_vreg;                    // R10
    acc = w ? (d[5:0] & lg) : 6'h00;
    rej = w && ((d[5:0] & ~lg) != 6'h00);
    clr[0] = ev[1] & c[1];
    clr[1] = ev[1] & c[1];
    clr[2] = c[2] & ((ev[2] & sw & ~cfg_continuous) | (ev[3] & c[4]));
    clr[3] = ev[4] & c[3];
    clr[4] = ev[3] & c[4];
    clr[5] = ev[5] & c[5];
    launch = sw ? acc[2] : (c[2] & trig & ~m_trq);
    go = acc;
    go[2] = launch;
    go[3] = acc[3] | (launch & cfg_auto_inj);
    if (clr[0]) m_rdy = 1'b0;
    else if (ev[0] && c[0] && !c[1]) m_rdy = 1'b1;
    m_err = m_err | rej;
    if (w) m_vreg = d[6];
    m_trq = trig;
    m_cmd = (c & ~clr) | acc;
    exp_word = '0;
    exp_word[5:0] = m_cmd;
    exp_word[6]   = m_vreg;
    exp_word[8]   = m_rdy;
    exp_word[9]   = m_err;
    exp_go = go;
  endtask

  task automatic cyc(input string tag, input logic w, input logic [6:0] d,
                     input logic [5:0] ev, input logic trig);
    bus_wr = w;
    bus_wdata = d;
    {core_cal_done, core_inj_end, core_stop_done, core_seq_end, core_off, core_ready} = ev;
    hw_trig = trig;
    model_step(w, d, ev, trig);
    @(posedge clk);
    @(negedge clk);
    check({tag, " readback"}, 32'(bus_rdata), bus_rd ? 32'(exp_word) : 32'h0);
    check({tag, " pulses"},
          32'({go_calib, go_stop, go_inj_conv, go_reg_conv, go_disable, go_enable}),
          32'(exp_go));
    bus_wr = 1'b0;
    {core_cal_done, core_inj_end, core_stop_done, core_seq_end, core_off, core_ready} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13 reset state
    check("R13 reset readback", 32'(bus_rdata), 32'h0);
    check("R13 reset pulses",
          32'({go_calib, go_stop, go_inj_conv, go_reg_conv, go_disable, go_enable}), 32'h0);
    cyc("R1 enable refused without regulator", 1, W_EN, 0, 0);
    cyc("R12 regulator bit written", 1, W_VR, 0, 0);
    cyc("R12 zeros to commands ignored", 1, W_VR, 0, 0);
    cyc("R11 stop refused while idle", 1, W_VR | W_STP, 0, 0);
    cyc("R10 calibrate wins over enable", 1, W_VR | W_EN | W_CAL, 0, 0);
    cyc("R10 calibrate held", 0, 0, 0, 0);
    cyc("R10 calibrate done clears", 0, 0, E_CAL, 0);
    cyc("R1 enable accepted", 1, W_VR | W_EN, 0, 0);
    cyc("R13 enable pulse single cycle", 0, 0, 0, 0);
    cyc("R2 ready low before core event", 0, 0, 0, 0);
    cyc("R2 ready set", 0, 0, E_RDY, 0);
    cyc("R10 calibrate refused while enabled", 1, W_VR | W_CAL, 0, 0);
    cyc("R5 regular start software trigger", 1, W_VR | W_RS, 0, 0);
    cyc("R3 disable refused during conversion", 1, W_VR | W_DIS, 0, 0);
    cyc("R6 sequence end clears in single mode", 0, 0, E_EOS, 0);
    cfg_continuous = 1'b1;
    cyc("R6 start in continuous mode", 1, W_VR | W_RS, 0, 0);
    cyc("R6 continuous keeps start", 0, 0, E_EOS, 0);
    cyc("R8 stop accepted", 1, W_VR | W_STP, 0, 0);
    cyc("R8 stop held", 0, 0, 0, 0);
    cyc("R8 stop done clears stop and start", 0, 0, E_STP, 0);
    cfg_trig_sel = 2'd1;
    cyc("R7 arm without launch", 1, W_VR | W_RS, 0, 0);
    cyc("R7 rising edge launches", 0, 0, 0, 1);
    cyc("R7 held trigger no relaunch", 0, 0, 0, 1);
    cyc("R7 trigger low", 0, 0, 0, 0);
    cyc("R7 sequence end ignored", 0, 0, E_EOS, 0);
    cyc("R7 second edge launches", 0, 0, 0, 1);
    cyc("R8 stop in hardware mode", 1, W_VR | W_STP, 0, 0);
    cyc("R8 stop done", 0, 0, E_STP, 0);
    cfg_trig_sel = '0;
    cfg_auto_inj = 1'b1;
    cyc("R9 injected refused in auto mode", 1, W_VR | W_JS, 0, 0);
    cyc("R9 auto launch pairs", 1, W_VR | W_RS, 0, 0);
    cyc("R9 stop", 1, W_VR | W_STP, 0, 0);
    cyc("R9 stop done", 0, 0, E_STP, 0);
    cfg_auto_inj = 1'b0;
    cyc("R9 injected start accepted", 1, W_VR | W_JS, 0, 0);
    cyc("R9 injected end clears", 0, 0, E_INJ, 0);
    bus_rd = 1'b0;
    cyc("R12 readback gated", 0, 0, 0, 0);
    bus_rd = 1'b1;
    cyc("R3 disable accepted", 1, W_VR | W_DIS, 0, 0);
    cyc("R5 start refused while disabling", 1, W_VR | W_RS, 0, 0);
    cyc("R4 disable held", 0, 0, 0, 0);
    cyc("R4 off clears enable and disable", 0, 0, E_OFF, 0);
    cyc("R2 ready ignored while off", 0, 0, E_RDY, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] d;
      logic [5:0] ev;
      if (n % 128 == 0) begin
        cfg_trig_sel   = TW'($urandom);
        cfg_continuous = 1'($urandom);
        cfg_auto_inj   = (($urandom % 4) == 0);
      end
      bus_rd = (($urandom % 16) != 0);
      d = 7'($urandom);
      d[6] = (($urandom % 8) != 0);
      for (int k = 0; k < 6; k++) ev[k] = (($urandom % 6) == 0);
      cyc("R11 random mix", (($urandom % 3) == 0), d, ev,
          (($urandom % 4) == 0) ? ~hw_trig : hw_trig);
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule